// File: doc/BRIEF.md
# Gamepad Mapper with Overlay Menu Toggle

This block takes a 32-bit vector of pressed controller buttons, qualified by an update strobe, and produces two things on every update: a bank of active-low button lines that go straight to a handheld console, and an 8-bit command byte for the on-screen menu of a video scaler. A request strobe tells the downstream serial sender to ship that byte.

A dedicated menu button switches overlay mode on and off. The switch happens when the button is let go after a press, not when it goes down. While overlay mode is on, the console lines are frozen at their last value. The directional pad and the two main face buttons still reach the scaler through the command byte, so the user can drive the menu without the game seeing any input.

Top module: `pad_overlay_mapper`

## Requirements
- R1: Every console line is active low: 0 while its source button is pressed, 1 otherwise. The line indices map from input bits as follows. Line 0 is up (bit 11). Line 1 is down (bit 10). Line 2 is left (bit 8). Line 3 is right (bit 9). Line 4 is face south (bit 18). Line 5 is face east (bit 17). Line 6 is face west (bit 16). Line 7 is face north (bit 19). Line 8 is start (bit 20). Line 9 is select (bit 21). Line 10 is menu (bit 22).
- R2: After reset, every console line is 1 except line RST_LOW_LINE (default 9), which is 0. The command byte is 0x00 and the send request is low.
- R3: Overlay mode flips on the first update in which the menu button (bit 22) is not pressed, provided an earlier update saw it pressed. An update with the menu button pressed never flips the mode.
- R4: An update that begins with overlay mode on leaves the console lines unchanged. This includes the update that turns the mode off. The update after that one drives the lines from the live vector again.
- R5: Bits 5:0 of the command byte follow the live vector on every update, in any mode. Bit 0 is face west, bit 1 is face south, bit 2 is left, bit 3 is right, bit 4 is down and bit 5 is up.
- R6: Bit 6 of the command byte is the overlay-mode flag after the update. Bit 7 is always 0.
- R7: Each update strobe yields exactly one single-cycle send request in the following cycle, with the updated command byte valid in that cycle.
- R8: Without an update strobe, the console lines, the command byte and the send request do not change, whatever the input vector does.
- R9: Line 11 is asserted when either bit 24 or bit 25 is pressed. Line 12 is asserted when either bit 28 or bit 29 is pressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | Update strobe qualifying btn_i |
| btn_i | input | 32 | Pressed-button vector, 1 = pressed |
| pins_o | output | 13 | Active-low console button lines |
| ovl_byte_o | output | 8 | Command byte for the scaler menu |
| send_o | output | 1 | One-cycle request to transmit ovl_byte_o |

## Verification
The hardest state to reach is the update that turns overlay mode off. It must still leave the console lines frozen, because the freeze is decided by the mode at the start of the update. To get there, the stimulus presses and releases the menu button to enter the mode, then sends direction and face presses that must only reach the byte. It then presses and releases the menu button again and checks that the lines are still at their old value. Only the update after that is expected to move them.

// File: rtl/pad_overlay_pkg.sv
// Package: shared input bit positions, line count and source lookup for the
// gamepad mapper. Assumes a 32-bit pressed vector with 1 = pressed.
package pad_overlay_pkg;
    localparam int IN_W        = 32;
    localparam int IN_LEFT     = 8;
    localparam int IN_RIGHT    = 9;
    localparam int IN_DOWN     = 10;
    localparam int IN_UP       = 11;
    localparam int IN_FACE_W   = 16;
    localparam int IN_FACE_E   = 17;
    localparam int IN_FACE_S   = 18;
    localparam int IN_FACE_N   = 19;
    localparam int IN_START    = 20;
    localparam int IN_SELECT   = 21;
    localparam int IN_MENU     = 22;
    localparam int IN_SHL_A    = 24;
    localparam int IN_SHL_B    = 25;
    localparam int IN_SHR_A    = 28;
    localparam int IN_SHR_B    = 29;

    localparam int N_SINGLE    = 11;
    localparam int N_LINES     = N_SINGLE + 2;
    localparam int N_OVL_BITS  = 6;

    // Source input bit for each single-button console line
    function automatic int single_src(input int line);
        case (line)
            0:       return IN_UP;
            1:       return IN_DOWN;
            2:       return IN_LEFT;
            3:       return IN_RIGHT;
            4:       return IN_FACE_S;
            5:       return IN_FACE_E;
            6:       return IN_FACE_W;
            7:       return IN_FACE_N;
            8:       return IN_START;
            9:       return IN_SELECT;
            default: return IN_MENU;
        endcase
    endfunction

    // Source input bit for each menu-byte bit 0..5
    function automatic int ovl_src(input int bitpos);
        case (bitpos)
            0:       return IN_FACE_W;
            1:       return IN_FACE_S;
            2:       return IN_LEFT;
            3:       return IN_RIGHT;
            4:       return IN_DOWN;
            default: return IN_UP;
        endcase
    endfunction
endpackage

// File: rtl/pad_line_map.sv
// Combinational map from the pressed vector to per-line "asserted" flags.
// Single lines copy one input. The two shoulder lines OR a pair of inputs.
module pad_line_map
    import pad_overlay_pkg::*;
(
    input  logic [IN_W-1:0]    vec_i,
    output logic [N_LINES-1:0] asserted_o
);
    // One line per single-button source
    for (genvar g = 0; g < N_SINGLE; g++) begin : g_single
        assign asserted_o[g] = vec_i[single_src(g)];
    end

    // Shoulder pairs share one line each
    assign asserted_o[N_SINGLE]     = vec_i[IN_SHL_A] | vec_i[IN_SHL_B];
    assign asserted_o[N_SINGLE + 1] = vec_i[IN_SHR_A] | vec_i[IN_SHR_B];
endmodule

// File: rtl/pad_ovl_encode.sv
// Combinational packing of directions and the two face buttons into the low
// bits of the menu byte. Assumes ovl_src() defines the bit order.
module pad_ovl_encode
    import pad_overlay_pkg::*;
(
    input  logic [IN_W-1:0]       vec_i,
    output logic [N_OVL_BITS-1:0] bits_o
);
    for (genvar g = 0; g < N_OVL_BITS; g++) begin : g_bit
        assign bits_o[g] = vec_i[ovl_src(g)];
    end
endmodule

// File: rtl/pad_menu_toggle.sv
// Tracks menu press/release and flips the overlay mode on release.
// Assumes upd_i qualifies menu_i. The state changes only on update cycles.
module pad_menu_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    input  logic menu_i,
    output logic active_o
);
    logic pend_q;

    // Arm on press, flip the mode on the first released update after it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            active_o <= 1'b0;
        end else if (upd_i) begin
            if (menu_i) begin
                pend_q <= 1'b1;
            end else if (pend_q) begin
                pend_q   <= 1'b0;
                active_o <= ~active_o;
            end
        end
    end
endmodule

// File: rtl/pad_overlay_mapper.sv
// Top: drives the active-low console lines, freezes them in overlay mode,
// builds the menu byte and pulses a send request one cycle after each update.
// Assumes btn_i is only meaningful while upd_i is high.
module pad_overlay_mapper
    import pad_overlay_pkg::*;
#(
    parameter int RST_LOW_LINE = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_i,
    input  logic [IN_W-1:0]    btn_i,
    output logic [N_LINES-1:0] pins_o,
    output logic [7:0]         ovl_byte_o,
    output logic               send_o
);
    localparam logic [N_LINES-1:0] PINS_RST =
        ~(N_LINES'(1) << RST_LOW_LINE);

    logic [N_LINES-1:0]    asserted;
    logic [N_OVL_BITS-1:0] enc;
    logic [N_OVL_BITS-1:0] enc_q;
    logic                  active;

    pad_line_map u_map (
        .vec_i      (btn_i),
        .asserted_o (asserted)
    );

    pad_ovl_encode u_enc (
        .vec_i  (btn_i),
        .bits_o (enc)
    );

    pad_menu_toggle u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (upd_i),
        .menu_i   (btn_i[IN_MENU]),
        .active_o (active)
    );

    // Register lines (gated by the mode at update start), byte bits, send strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_o <= PINS_RST;
            enc_q  <= '0;
            send_o <= 1'b0;
        end else begin
            send_o <= upd_i;
            if (upd_i) begin
                enc_q <= enc;
                if (!active) pins_o <= ~asserted;
            end
        end
    end

    // Byte layout: bit7 zero, bit6 mode flag, bits 5:0 live buttons
    always_comb ovl_byte_o = {1'b0, active, enc_q};
endmodule

// File: rtl/pad_overlay_mapper_chk.sv
// Checker for pad_overlay_mapper, attached by bind below.
module pad_overlay_mapper_chk
    import pad_overlay_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               upd_i,
    input logic [IN_W-1:0]    btn_i,
    input logic [N_LINES-1:0] pins_o,
    input logic [7:0]         ovl_byte_o,
    input logic               send_o
);
    p_hold_in_overlay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && ovl_byte_o[6]) |=> $stable(pins_o));

    p_no_flip_on_press_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && btn_i[IN_MENU]) |=> $stable(ovl_byte_o[6]));

    p_send_after_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> send_o);

    p_no_send_without_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> !send_o);

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> ($stable(pins_o) && $stable(ovl_byte_o)));

    p_live_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> (ovl_byte_o[5] == $past(btn_i[IN_UP])));

    p_top_bit_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        send_o |-> !ovl_byte_o[7]);
endmodule

bind pad_overlay_mapper pad_overlay_mapper_chk u_chk (.*);

// File: tb/pad_overlay_mapper_tb.sv
module pad_overlay_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_i = 1'b0;
    logic [31:0] btn_i = '0;
    logic [12:0] pins_o;
    logic [7:0]  ovl_byte_o;
    logic        send_o;

    always #10 clk = ~clk;

    pad_overlay_mapper u_dut (.*);

    typedef struct {
        logic [12:0] pins;
        logic [7:0]  byte_v;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0, bad = 0, n_upd = 0, n_send = 0;
    logic [12:0] m_pins;
    logic m_act, m_pend;

    function automatic logic [12:0] model_pins(input logic [31:0] v);
        logic [12:0] a;
        a[0] = v[11]; a[1] = v[10]; a[2] = v[8];  a[3] = v[9];
        a[4] = v[18]; a[5] = v[17]; a[6] = v[16]; a[7] = v[19];
        a[8] = v[20]; a[9] = v[21]; a[10] = v[22];
        a[11] = v[24] | v[25]; a[12] = v[28] | v[29];
        return ~a;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: update the model, push the expected item, strobe once
    task automatic apply(input logic [31:0] v, input string tag);
        exp_t e;
        if (!m_act) m_pins = model_pins(v);
        if (v[22]) m_pend = 1'b1;
        else if (m_pend) begin m_pend = 1'b0; m_act = ~m_act; end
        e.pins = m_pins;
        e.byte_v = {1'b0, m_act, v[11], v[10], v[9], v[8], v[18], v[16]};
        e.tag = tag;
        q.push_back(e);
        @(negedge clk); btn_i = v; upd_i = 1'b1; n_upd++;
        @(negedge clk); upd_i = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pop and compare on each send request
    always @(negedge clk) begin
        if (rst_n && send_o) begin
            exp_t e;
            n_send++;
            if (q.size() == 0) begin
                total++; bad++;
                $display("FAIL R7 unexpected send actual=1 expected=0");
            end else begin
                e = q.pop_front();
                check({e.tag, " pins"}, 32'(pins_o), 32'(e.pins));
                check({e.tag, " byte"}, 32'(ovl_byte_o), 32'(e.byte_v));
            end
        end
    end

    task automatic idle_check(input string tag);
        logic [12:0] p0; logic [7:0] b0;
        p0 = pins_o; b0 = ovl_byte_o;
        btn_i = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check({tag, " pins"}, 32'(pins_o), 32'(p0));
        check({tag, " byte"}, 32'(ovl_byte_o), 32'(b0));
        check({tag, " send"}, 32'(send_o), 32'd0);
    endtask

    initial begin
        m_pins = 13'h1FFF & ~(13'd1 << 9); m_act = 1'b0; m_pend = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset pins", 32'(pins_o), 32'(13'h1DFF));
        check("R2 reset byte", 32'(ovl_byte_o), 32'h00);
        check("R2 reset send", 32'(send_o), 32'd0);
        idle_check("R8 idle before update");
        apply(32'h0001_0800, "R1 R5 up and face west");
        apply(32'h0004_0100, "R1 R5 left and face south");
        apply(32'h0000_0000, "R1 all released");
        apply(32'h0200_0000, "R9 left shoulder second input");
        apply(32'h1000_0000, "R9 right shoulder first input");
        apply(32'h3300_0000, "R9 both pairs");
        apply(32'h0040_0000, "R3 menu press no flip");
        apply(32'h0000_0000, "R3 menu release flips on");
        apply(32'h0005_0A00, "R4 R5 R6 held lines live byte");
        idle_check("R8 idle in overlay");
        apply(32'h0040_0200, "R4 menu press in overlay");
        apply(32'h0000_0400, "R4 release flips off lines still held");
        apply(32'h0030_0900, "R4 lines follow again");
        apply(32'hFFFF_FFFF, "R1 R6 everything pressed");
        apply(32'h0000_0000, "R3 release of all flips on");
        repeat (3) @(negedge clk);
        check("R7 sends per update", 32'(n_send), 32'(n_upd));
        check("R7 queue drained", 32'(q.size()), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule